// File: doc/BRIEF.md
# Fetch-Stage Branch Predictor with Return Stack

This block tells the instruction fetch stage where to fetch next. For each fetch address it reports whether a taken branch is expected and which target to use. When it expects no taken branch, it reports the sequential address, which is the fetch address plus 4. The prediction has three sources:

- **Target cache.** A two-way set-associative cache holds branch targets and selects the victim with one LRU bit per set.
- **Direction table.** A table of 2-bit saturating counters decides conditional branches. It is indexed by the fetch address XORed with a global history of resolved conditional outcomes.
- **Return stack.** A circular stack of return addresses serves return instructions.

Predecode hints from the fetch stage mark a fetch as a call, a return or a conditional branch. The execute stage reports each resolved branch through an update port.

Prediction comes up switched off after reset. It follows a single enable input, which is registered, so a change takes effect one cycle later. While prediction is off:

- The outputs always give the sequential address.
- Resolve updates still train the target cache and the direction table. That training shows up once prediction is switched on.
- Call and return hints leave the return stack untouched.

Lookup is combinational from the fetch inputs and reads the state as it was before the current clock edge. Updates and stack operations take effect at the clock edge.

Top module: `branch_predictor`

## Requirements
- R1: After reset, prediction is off. Until enable_i has been sampled high at a clock edge, pred_taken_o is 0 and pred_target_o is fetch_pc_i+4. After reset, the target cache holds no entries.
- R2: In any cycle where enable_i was low at the previous clock edge, pred_taken_o is 0 and pred_target_o is fetch_pc_i+4, whatever the hints and the stored state. Resolves in such cycles still update the cache and the counters. Call and return hints in such cycles do not touch the return stack.
- R3: With prediction on, a fetch without the return hint and without the conditional hint predicts taken with the stored target whenever its address hits in the target cache. This holds from the cycle after the resolve that wrote the entry.
- R4: A resolve with upd_taken_i=1 that misses in the target cache allocates an entry. The set is pc[9:2] and the tag is pc[31:10]. An invalid way is used first, then the way named by the set's LRU bit. A resolve with upd_taken_i=0 allocates nothing.
- R5: Every taken resolve that hits or allocates makes the other way of that set the next victim. A third taken branch in a full set therefore evicts the least recently resolved one.
- R6: A taken resolve that hits replaces the stored target only when upd_mispred_i=1. Otherwise the old target is kept.
- R7: A fetch with the conditional hint that hits in the target cache predicts taken exactly when its counter is in state 2 or 3. The counter encoding is 0 strongly not taken, 1 weakly not taken, 2 weakly taken, 3 strongly taken. The counter index is pc[13:2] XOR the history. All counters reset to 1. A conditional fetch that misses predicts not taken.
- R8: A resolve with upd_cond_i=1 moves the indexed counter one step toward the outcome, saturating at 0 and 3. A resolve with upd_cond_i=0 leaves the counters and the history unchanged.
- R9: The 12-bit history resets to 0. Each conditional resolve shifts its outcome into bit 0, and the index for that resolve uses the history from before the shift.
- R10: A fetch with the call hint pushes fetch_pc_i+4. A fetch with the return hint pops the stack and predicts taken to the popped address, in last-in first-out order.
- R11: A return hint on an empty stack predicts not taken with fetch_pc_i+4, and the stack stays empty.
- R12: The stack holds 8 entries. A push onto a full stack overwrites the oldest entry, so after 10 pushes the 8 newest come back in reverse order, and the next return finds the stack empty.
- R13: When the call and return hints arrive together, the return is served, taking precedence over the target cache, and the call is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Prediction enable, registered before use |
| fetch_valid_i | input | 1 | A fetch address is presented this cycle |
| fetch_pc_i | input | 32 | Fetch address |
| hint_call_i | input | 1 | Predecode: call with link |
| hint_ret_i | input | 1 | Predecode: return |
| hint_cond_i | input | 1 | Predecode: conditional branch |
| upd_valid_i | input | 1 | A resolved branch is reported |
| upd_pc_i | input | 32 | Address of the resolved branch |
| upd_taken_i | input | 1 | Resolved outcome |
| upd_cond_i | input | 1 | Resolved branch is conditional |
| upd_target_i | input | 32 | Resolved target |
| upd_mispred_i | input | 1 | The earlier prediction for this branch was wrong |
| pred_taken_o | output | 1 | Taken predicted |
| pred_target_o | output | 32 | Next fetch address |

## Verification
The hardest states to reach from the ports are the saturated direction counters and an LRU eviction. Each counter is hidden behind a history that changes with every conditional resolve, and an eviction needs a full set. The stimulus does three things:

- It resolves one conditional branch many times in a row until the history saturates at all ones, so the same counter is driven to its strong state and then stepped back.
- It steers three taken branches into one set, re-resolving one of them before the third arrives, so the eviction order can be read from the fetch predictions.
- It overflows the return stack with ten nested calls before unwinding it.

The bench keeps its own model of all three structures, and the expected prediction for every fetch comes from that model.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef enum logic [1:0] {
    CTR_SNT = 2'd0,
    CTR_WNT = 2'd1,
    CTR_WT  = 2'd2,
    CTR_ST  = 2'd3
  } ctr_e;

  function automatic ctr_e ctr_step(ctr_e cur, logic taken);
    ctr_e nxt;
    case (cur)
      CTR_SNT: nxt = taken ? CTR_WNT : CTR_SNT;
      CTR_WNT: nxt = taken ? CTR_WT  : CTR_SNT;
      CTR_WT:  nxt = taken ? CTR_ST  : CTR_WNT;
      default: nxt = taken ? CTR_ST  : CTR_WT;
    endcase
    return nxt;
  endfunction

  function automatic logic ctr_taken(ctr_e cur);
    return (cur == CTR_WT) || (cur == CTR_ST);
  endfunction
endpackage

// File: rtl/bp_btb.sv
module bp_btb #(
  parameter int PC_W = 32,
  parameter int SETS = 256
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] look_pc_i,
  output logic            look_hit_o,
  output logic [PC_W-1:0] look_tgt_o,
  input  logic            upd_en_i,
  input  logic [PC_W-1:0] upd_pc_i,
  input  logic [PC_W-1:0] upd_tgt_i,
  input  logic            upd_fix_i
);
  localparam int WAYS  = 2;
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = PC_W - IDX_W - 2;

  logic [TAG_W-1:0] tag_q [WAYS][SETS];
  logic [PC_W-1:0]  tgt_q [WAYS][SETS];
  logic [WAYS-1:0]  vld_q [SETS];
  logic [SETS-1:0]  lru_q;

  logic [IDX_W-1:0] l_set, u_set;
  logic [TAG_W-1:0] l_tag, u_tag;
  logic [WAYS-1:0]  l_match, u_match;
  logic             u_hit, victim, wr_way, wr_data;
  logic             unused_lsb;

  assign l_set = look_pc_i[IDX_W+1:2];
  assign l_tag = look_pc_i[PC_W-1:IDX_W+2];
  assign u_set = upd_pc_i[IDX_W+1:2];
  assign u_tag = upd_pc_i[PC_W-1:IDX_W+2];
  assign unused_lsb = ^{look_pc_i[1:0], upd_pc_i[1:0]};

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign l_match[w] = vld_q[l_set][w] && (tag_q[w][l_set] == l_tag);
    assign u_match[w] = vld_q[u_set][w] && (tag_q[w][u_set] == u_tag);
  end

  always_comb begin
    look_tgt_o = '0;
    for (int w = 0; w < WAYS; w++)
      if (l_match[w]) look_tgt_o = tgt_q[w][l_set];
  end
  assign look_hit_o = |l_match;

  assign u_hit   = |u_match;
  assign victim  = !vld_q[u_set][0] ? 1'b0 :
                   !vld_q[u_set][1] ? 1'b1 : lru_q[u_set];
  assign wr_way  = u_hit ? u_match[1] : victim;
  assign wr_data = !u_hit || upd_fix_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
      lru_q <= '0;
    end else if (upd_en_i) begin
      vld_q[u_set][wr_way] <= 1'b1;
      lru_q[u_set]         <= ~wr_way;
    end
  end

  always_ff @(posedge clk_i) begin
    if (upd_en_i && wr_data) begin
      tag_q[wr_way][u_set] <= u_tag;
      tgt_q[wr_way][u_set] <= upd_tgt_i;
    end
  end

  // R4: written way is valid afterwards
  a_r4_alloc_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_en_i |=> vld_q[$past(u_set)][$past(wr_way)]);
  // R5: LRU points away from the way just used
  a_r5_lru_other: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_en_i |=> lru_q[$past(u_set)] != $past(wr_way));
endmodule

// File: rtl/bp_dir.sv
module bp_dir import bp_pkg::*; #(
  parameter int HIST_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HIST_W-1:0] look_idx_i,
  output logic              look_taken_o,
  input  logic              upd_en_i,
  input  logic [HIST_W-1:0] upd_idx_i,
  input  logic              upd_taken_i
);
  localparam int ENTRIES = 1 << HIST_W;

  ctr_e              pht_q [ENTRIES];
  logic [HIST_W-1:0] ghr_q;
  logic [HIST_W-1:0] l_idx, u_idx;

  assign l_idx = look_idx_i ^ ghr_q;
  assign u_idx = upd_idx_i ^ ghr_q;
  assign look_taken_o = ctr_taken(pht_q[l_idx]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ghr_q <= '0;
      for (int i = 0; i < ENTRIES; i++) pht_q[i] <= CTR_WNT;
    end else if (upd_en_i) begin
      pht_q[u_idx] <= ctr_step(pht_q[u_idx], upd_taken_i);
      ghr_q        <= {ghr_q[HIST_W-2:0], upd_taken_i};
    end
  end

  a_r9_hist_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_en_i |=> ghr_q[0] == $past(upd_taken_i));
  a_r8_sat_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_en_i && upd_taken_i && pht_q[u_idx] == CTR_ST |=> pht_q[$past(u_idx)] == CTR_ST);
  a_r8_sat_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_en_i && !upd_taken_i && pht_q[u_idx] == CTR_SNT |=> pht_q[$past(u_idx)] == CTR_SNT);
endmodule

// File: rtl/bp_ras.sv
module bp_ras #(
  parameter int PC_W  = 32,
  parameter int DEPTH = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  logic            pop_i,
  input  logic [PC_W-1:0] push_data_i,
  output logic            top_valid_o,
  output logic [PC_W-1:0] top_data_o
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [PC_W-1:0]  stk_q [DEPTH];
  logic [PTR_W-1:0] ptr_q, top_idx;
  logic [CNT_W-1:0] cnt_q;
  logic             do_pop;

  assign top_idx     = ptr_q - PTR_W'(1);
  assign top_data_o  = stk_q[top_idx];
  assign top_valid_o = (cnt_q != '0);
  assign do_pop      = pop_i && top_valid_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else if (do_pop) begin
      ptr_q <= top_idx;
      cnt_q <= cnt_q - CNT_W'(1);
    end else if (push_i) begin
      ptr_q <= ptr_q + PTR_W'(1);
      if (cnt_q != CNT_W'(DEPTH)) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // circular store: a push on a full stack lands on the oldest slot
  always_ff @(posedge clk_i) begin
    if (push_i && !pop_i) stk_q[ptr_q] <= push_data_i;
  end

  a_r12_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  a_r10_push_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !pop_i |=> top_valid_o && top_data_o == $past(push_data_i));
  a_r11_empty_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && !push_i && !top_valid_o |=> !top_valid_o);
endmodule

// File: rtl/branch_predictor.sv
module branch_predictor import bp_pkg::*; #(
  parameter int PC_W      = 32,
  parameter int BTB_SETS  = 256,
  parameter int HIST_W    = 12,
  parameter int RAS_DEPTH = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            enable_i,
  input  logic            fetch_valid_i,
  input  logic [PC_W-1:0] fetch_pc_i,
  input  logic            hint_call_i,
  input  logic            hint_ret_i,
  input  logic            hint_cond_i,
  input  logic            upd_valid_i,
  input  logic [PC_W-1:0] upd_pc_i,
  input  logic            upd_taken_i,
  input  logic            upd_cond_i,
  input  logic [PC_W-1:0] upd_target_i,
  input  logic            upd_mispred_i,
  output logic            pred_taken_o,
  output logic [PC_W-1:0] pred_target_o
);
  logic            en_q, active;
  logic            btb_hit, dir_taken, ras_valid;
  logic [PC_W-1:0] btb_tgt, ras_top, seq_pc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= enable_i;
  end

  assign active = en_q && fetch_valid_i;
  assign seq_pc = fetch_pc_i + PC_W'(4);

  bp_btb #(.PC_W(PC_W), .SETS(BTB_SETS)) i_btb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .look_pc_i  (fetch_pc_i),
    .look_hit_o (btb_hit),
    .look_tgt_o (btb_tgt),
    .upd_en_i   (upd_valid_i && upd_taken_i),
    .upd_pc_i   (upd_pc_i),
    .upd_tgt_i  (upd_target_i),
    .upd_fix_i  (upd_mispred_i)
  );

  bp_dir #(.HIST_W(HIST_W)) i_dir (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .look_idx_i   (fetch_pc_i[HIST_W+1:2]),
    .look_taken_o (dir_taken),
    .upd_en_i     (upd_valid_i && upd_cond_i),
    .upd_idx_i    (upd_pc_i[HIST_W+1:2]),
    .upd_taken_i  (upd_taken_i)
  );

  bp_ras #(.PC_W(PC_W), .DEPTH(RAS_DEPTH)) i_ras (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (active && hint_call_i && !hint_ret_i),
    .pop_i       (active && hint_ret_i),
    .push_data_i (seq_pc),
    .top_valid_o (ras_valid),
    .top_data_o  (ras_top)
  );

  always_comb begin
    pred_taken_o  = 1'b0;
    pred_target_o = seq_pc;
    if (active) begin
      if (hint_ret_i) begin
        if (ras_valid) begin
          pred_taken_o  = 1'b1;
          pred_target_o = ras_top;
        end
      end else if (btb_hit && (!hint_cond_i || dir_taken)) begin
        pred_taken_o  = 1'b1;
        pred_target_o = btb_tgt;
      end
    end
  end

  a_r2_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(enable_i) |-> !pred_taken_o);
  a_r2_needs_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_taken_o |-> fetch_valid_i);
endmodule

// File: tb/test_branch_predictor.sv
module test_branch_predictor;
  logic        clk = 0, rst_ni = 0, enable_i = 0;
  logic        fetch_valid_i = 0, hint_call_i = 0, hint_ret_i = 0, hint_cond_i = 0;
  logic [31:0] fetch_pc_i = 0, upd_pc_i = 0, upd_target_i = 0, pred_target_o;
  logic        upd_valid_i = 0, upd_taken_i = 0, upd_cond_i = 0, upd_mispred_i = 0, pred_taken_o;

  always #2.5 clk = ~clk;

  branch_predictor i_branch_predictor (
    .clk_i(clk), .rst_ni(rst_ni), .enable_i(enable_i),
    .fetch_valid_i(fetch_valid_i), .fetch_pc_i(fetch_pc_i),
    .hint_call_i(hint_call_i), .hint_ret_i(hint_ret_i), .hint_cond_i(hint_cond_i),
    .upd_valid_i(upd_valid_i), .upd_pc_i(upd_pc_i), .upd_taken_i(upd_taken_i),
    .upd_cond_i(upd_cond_i), .upd_target_i(upd_target_i), .upd_mispred_i(upd_mispred_i),
    .pred_taken_o(pred_taken_o), .pred_target_o(pred_target_o)
  );

  typedef struct {
    bit          tk;
    logic [31:0] tg;
    string       rq;
  } exp_t;
  exp_t sb_q[$];
  event samp_ev;
  int   n_cmp = 0, n_bad = 0;
  bit   done = 0;

  // reference model
  bit          en_m = 0, en_drv = 0;
  int          m_pht[4096];
  int          m_ghr = 0;
  bit          m_v  [256][2];
  logic [21:0] m_tag[256][2];
  logic [31:0] m_tg [256][2];
  bit          m_lru[256];
  logic [31:0] m_ras[$];

  function automatic int btb_find(logic [31:0] pc);
    for (int w = 0; w < 2; w++)
      if (m_v[pc[9:2]][w] && m_tag[pc[9:2]][w] == pc[31:10]) return w;
    return -1;
  endfunction

  task automatic model_update(logic [31:0] pc, bit tk, bit cnd, logic [31:0] tgt, bit mis);
    int s, w, idx;
    if (cnd) begin
      idx = int'(pc[13:2]) ^ m_ghr;
      if (tk && m_pht[idx] < 3) m_pht[idx]++;
      if (!tk && m_pht[idx] > 0) m_pht[idx]--;
      m_ghr = ((m_ghr << 1) | int'(tk)) & 12'hFFF;
    end
    if (tk) begin
      s = int'(pc[9:2]);
      w = btb_find(pc);
      if (w >= 0) begin
        if (mis) m_tg[s][w] = tgt;
      end else begin
        w = !m_v[s][0] ? 0 : !m_v[s][1] ? 1 : int'(m_lru[s]);
        m_v[s][w] = 1; m_tag[s][w] = pc[31:10]; m_tg[s][w] = tgt;
      end
      m_lru[s] = (w == 0);
    end
  endtask

  task automatic step(bit fv, logic [31:0] pc, bit call, bit ret, bit cnd,
                      bit uv, logic [31:0] upc, bit utk, bit ucnd, logic [31:0] utg, bit umis,
                      string rq);
    exp_t e;
    int   w;
    @(negedge clk);
    enable_i = en_drv;
    fetch_valid_i = fv; fetch_pc_i = pc; hint_call_i = call; hint_ret_i = ret; hint_cond_i = cnd;
    upd_valid_i = uv; upd_pc_i = upc; upd_taken_i = utk; upd_cond_i = ucnd;
    upd_target_i = utg; upd_mispred_i = umis;
    e.tk = 0; e.tg = pc + 32'd4; e.rq = rq;
    if (en_m && fv) begin
      if (ret) begin
        if (m_ras.size() > 0) begin e.tk = 1; e.tg = m_ras[$]; end
      end else begin
        w = btb_find(pc);
        if (w >= 0 && (!cnd || m_pht[int'(pc[13:2]) ^ m_ghr] >= 2)) begin
          e.tk = 1; e.tg = m_tg[pc[9:2]][w];
        end
      end
    end
    if (fv) begin
      sb_q.push_back(e);
      #1 ->samp_ev;
    end
    if (uv) model_update(upc, utk, ucnd, utg, umis);
    if (en_m && fv) begin
      if (ret) begin
        if (m_ras.size() > 0) void'(m_ras.pop_back());
      end else if (call) begin
        if (m_ras.size() == 8) void'(m_ras.pop_front());
        m_ras.push_back(pc + 32'd4);
      end
    end
    en_m = en_drv;
  endtask

  task automatic fetch(logic [31:0] pc, bit call, bit ret, bit cnd, string rq);
    step(1, pc, call, ret, cnd, 0, 0, 0, 0, 0, 0, rq);
  endtask

  task automatic resolve(logic [31:0] pc, bit tk, bit cnd, logic [31:0] tgt, bit mis);
    step(0, 0, 0, 0, 0, 1, pc, tk, cnd, tgt, mis, "");
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
  endtask

  // scoreboard monitor
  initial begin
    exp_t e;
    forever begin
      @(samp_ev);
      if (sb_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL scoreboard: sample without expectation");
      end else begin
        e = sb_q.pop_front();
        n_cmp++;
        if (pred_taken_o !== e.tk || pred_target_o !== e.tg) begin
          n_bad++;
          $display("FAIL %s: taken=%0b target=%h expected taken=%0b target=%h",
                   e.rq, pred_taken_o, pred_target_o, e.tk, e.tg);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4096; i++) m_pht[i] = 1;
    repeat (3) @(negedge clk);
    rst_ni = 1;

    // R1: enable high in first cycle is not yet visible; empty cache afterwards
    en_drv = 1;
    fetch(32'h100, 0, 0, 0, "R1");
    fetch(32'h100, 0, 0, 0, "R1");
    fetch(32'h100, 0, 1, 0, "R1");

    // R2: disabled, resolves still train, stack untouched
    en_drv = 0;
    idle();
    resolve(32'h400, 1, 0, 32'h800, 0);
    fetch(32'h400, 0, 0, 0, "R2");
    fetch(32'h400, 1, 0, 0, "R2");
    en_drv = 1;
    idle();
    fetch(32'h400, 0, 0, 0, "R3");
    fetch(32'h900, 0, 1, 0, "R2");   // stack still empty

    // R10 / R11
    fetch(32'h1000, 1, 0, 0, "R10");
    fetch(32'h2000, 1, 0, 0, "R10");
    fetch(32'h3000, 1, 0, 0, "R10");
    for (int i = 0; i < 3; i++) fetch(32'h4000, 0, 1, 0, "R10");
    fetch(32'h4000, 0, 1, 0, "R11");
    fetch(32'h4000, 0, 1, 0, "R11");

    // R13: return beats cache hit and call
    fetch(32'h5000, 1, 0, 0, "R10");
    fetch(32'h400, 1, 1, 0, "R13");
    fetch(32'h4000, 0, 1, 0, "R13");

    // R12: overflow
    for (int i = 0; i < 10; i++) fetch(32'h6000 + 32'(i * 16), 1, 0, 0, "R12");
    for (int i = 0; i < 9; i++) fetch(32'h4000, 0, 1, 0, "R12");

    // R4 / R5: three branches in set 0x10
    resolve(32'h1040, 1, 0, 32'hA000, 0);
    resolve(32'h2040, 1, 0, 32'hB000, 0);
    fetch(32'h1040, 0, 0, 0, "R4");
    fetch(32'h2040, 0, 0, 0, "R4");
    resolve(32'h3040, 0, 0, 32'hC000, 0);
    fetch(32'h3040, 0, 0, 0, "R4");
    resolve(32'h1040, 1, 0, 32'hA000, 0);
    resolve(32'h3040, 1, 0, 32'hC000, 0);
    fetch(32'h2040, 0, 0, 0, "R5");
    fetch(32'h1040, 0, 0, 0, "R5");
    fetch(32'h3040, 0, 0, 0, "R5");

    // R6: target refresh only on mispredict
    resolve(32'h1040, 1, 0, 32'hD000, 0);
    fetch(32'h1040, 0, 0, 0, "R6");
    resolve(32'h1040, 1, 0, 32'hD000, 1);
    fetch(32'h1040, 0, 0, 0, "R6");

    // R7 / R8 / R9: conditional branch at 0x7000
    fetch(32'h7000, 0, 0, 1, "R7");
    resolve(32'h7000, 1, 1, 32'h7100, 0);
    fetch(32'h7000, 0, 0, 1, "R7");
    fetch(32'h7000, 0, 0, 0, "R3");
    for (int i = 0; i < 14; i++) resolve(32'h7000, 1, 1, 32'h7100, 0);
    fetch(32'h7000, 0, 0, 1, "R8");
    for (int i = 0; i < 4; i++) begin
      resolve(32'h7000, 0, 1, 32'h7100, 0);
      fetch(32'h7000, 0, 0, 1, "R9");
    end
    for (int i = 0; i < 12; i++) resolve(32'h7000, 1, 1, 32'h7100, 0);
    resolve(32'h7000, 0, 1, 32'h7100, 0);
    for (int i = 0; i < 13; i++) resolve(32'h9000, 1, 1, 32'h9100, 0);
    fetch(32'h7000, 0, 0, 1, "R8");
    for (int i = 0; i < 5; i++) resolve(32'h8000, 1, 0, 32'h8100, 0);
    fetch(32'h7000, 0, 0, 1, "R8");
    fetch(32'hF000, 0, 0, 1, "R7");

    // R2: switching off again
    en_drv = 0;
    idle();
    fetch(32'h1040, 0, 0, 0, "R2");
    fetch(32'h7000, 0, 0, 1, "R2");

    idle();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule